// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers single-cycle interrupt requests from a small microcontroller's peripherals (bus reset, periodic timers, GPIO, a two-wire serial engine, the hub logic and five USB endpoints). It records each request in a pending flip-flop of its own. It then offers the CPU the jump-slot address of the most urgent request that is both pending and enabled. Each handler occupies a two-byte jump slot. Address zero is the reset entry, so source `i` vectors to `RESET_ADDR + SLOT_BYTES*(i+1)`.

Software sets the per-source enable bits through a byte-wide register port. The CPU's EI, DI and RETI instructions drive the global enable. When the CPU fetches a vector, it pulses `ack`. That clears the winning pending bit and closes the global enable until the handler returns. `irq_pending` reports whether any request is latched, whatever the enables.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While reset is low, and after it is released: no bit is pending, all enable bits read 0, the global enable is off, `irq` is 0, `irq_pending` is 0 and `vec_addr` equals the reset entry (0).
- R2: A 1 on `src_req[i]` at a rising edge sets pending bit i from the next cycle onward. The bit is set regardless of its enable, and it stays set until that source is accepted. `irq_pending` is 1 exactly when any pending bit is set.
- R3: A write (`reg_wr`=1) to `reg_addr`=a loads source 8a+k's enable from `reg_wdata[k]`. `reg_rdata` returns the enables of the addressed byte combinationally. Bits with no source behind them read 0.
- R4: `irq` is 1 exactly when the global enable is on and at least one pending bit has its enable set. A pending but disabled source never raises `irq`.
- R5: While `irq` is 1, `vec_addr` = 2*(i+1) for the winning source i (reset entry 0, slot size 2 bytes). While `irq` is 0, `vec_addr` = 0.
- R6: Among several pending, enabled sources, the lowest index (the lowest vector) wins.
- R7: `ack` while `irq`=1 clears the winner's pending bit and turns the global enable off from the next cycle. `ack` while `irq`=0 changes nothing.
- R8: `ei` or `reti` turns the global enable on and `di` turns it off. `di` wins over `ei`/`reti` in the same cycle, and an accepted `ack` wins over all of them.
- R9: Repeated requests on a source merge into one pending bit, which a single acceptance clears. A request that arrives in the same cycle that accepts that source leaves it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Request pulses, one per source (bit 0 = highest priority) |
| reg_wr | input | 1 | Enable register write strobe |
| reg_addr | input | AW | Enable register byte select |
| reg_wdata | input | REG_W | Enable register write data |
| reg_rdata | output | REG_W | Enable register read data |
| ei | input | 1 | Global enable set (EI) |
| di | input | 1 | Global enable clear (DI) |
| reti | input | 1 | Return from handler, sets global enable |
| ack | input | 1 | CPU vector fetch acknowledge |
| irq | output | 1 | Interrupt request to CPU |
| vec_addr | output | VEC_W | Jump slot of the winning source |
| irq_pending | output | 1 | Any request latched |

## Verification
The following take effect one clock edge after the cycle in which they are presented:
- requests
- enable writes
- EI/DI/RETI
- accepted acknowledges

`irq`, `vec_addr` and `irq_pending` then follow combinationally from that state. `reg_rdata` follows `reg_addr` in the same cycle. The bench drives inputs on the falling edge and compares all four outputs shortly afterwards against a reference model. The model is advanced only at the next rising edge, so each result is checked in the first cycle it is due.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // Jump slot address of source idx: slots follow the reset entry.
  function automatic int unsigned slot_of(int unsigned idx, int unsigned base,
                                          int unsigned stride);
    return base + stride * (idx + 1);
  endfunction
endpackage

// File: rtl/vic_enable_regs.sv
module vic_enable_regs #(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned REG_W   = 8,
  parameter int unsigned AW      = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [AW-1:0]      addr,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output logic [NUM_SRC-1:0] en
);
  localparam int unsigned NREG = (NUM_SRC + REG_W - 1) / REG_W;
  localparam int unsigned FULL = NREG * REG_W;

  logic [FULL-1:0] en_q, en_d, live_mask;

  for (genvar s = 0; s < FULL; s++) begin : g_mask
    assign live_mask[s] = (s < NUM_SRC);
  end

  always_comb begin
    en_d = en_q;
    if (wr && (int'(addr) < NREG)) begin
      en_d[int'(addr)*REG_W +: REG_W] = wdata;
    end
    en_d = en_d & live_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  always_comb begin
    rdata = '0;
    if (int'(addr) < NREG) rdata = en_q[int'(addr)*REG_W +: REG_W];
  end

  assign en = en_q[NUM_SRC-1:0];
endmodule

// File: rtl/vic_pending.sv
module vic_pending #(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] pend_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // a fresh request outweighs a clear in the same cycle
    assign pend_d[i] = req[i] | (pend[i] & ~clr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_d;
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int unsigned NUM_SRC    = 11,
  parameter int unsigned VEC_W      = 16,
  parameter int unsigned RESET_ADDR = 0,
  parameter int unsigned SLOT_BYTES = 2
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en,
  input  logic               gie,
  output logic               irq,
  output logic [NUM_SRC-1:0] win,
  output logic [VEC_W-1:0]   vec
);
  import vic_pkg::*;

  logic [NUM_SRC-1:0] live;
  logic               found;
  int unsigned        idx;

  assign live = pend & en;

  always_comb begin
    found = 1'b0;
    idx   = 0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (live[i]) begin
        found = 1'b1;
        idx   = i;
      end
    end
  end

  assign irq = gie & found;

  always_comb begin
    win = '0;
    if (found) win[idx] = 1'b1;
  end

  assign vec = irq ? VEC_W'(slot_of(idx, RESET_ADDR, SLOT_BYTES))
                   : VEC_W'(RESET_ADDR);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int unsigned NUM_SRC    = 11,
  parameter int unsigned REG_W      = 8,
  parameter int unsigned VEC_W      = 16,
  parameter int unsigned RESET_ADDR = 0,
  parameter int unsigned SLOT_BYTES = 2,
  parameter int unsigned NREG       = (NUM_SRC + REG_W - 1) / REG_W,
  parameter int unsigned AW         = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               ei,
  input  logic               di,
  input  logic               reti,
  input  logic               ack,
  output logic               irq,
  output logic [VEC_W-1:0]   vec_addr,
  output logic               irq_pending
);
  logic [NUM_SRC-1:0] en, pend, win, clr;
  logic               gie_q, gie_d, take;

  vic_enable_regs #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .AW(AW)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .en(en)
  );

  vic_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .req(src_req), .clr(clr), .pend(pend)
  );

  vic_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .RESET_ADDR(RESET_ADDR),
                .SLOT_BYTES(SLOT_BYTES)) u_arb (
    .pend(pend), .en(en), .gie(gie_q), .irq(irq), .win(win), .vec(vec_addr)
  );

  assign take = ack & irq;
  assign clr  = take ? win : '0;

  always_comb begin
    gie_d = gie_q;
    if (take)           gie_d = 1'b0;
    else if (di)        gie_d = 1'b0;
    else if (ei | reti) gie_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else        gie_q <= gie_d;
  end

  assign irq_pending = |pend;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int unsigned NUM_SRC    = 11,
  parameter int unsigned VEC_W      = 16,
  parameter int unsigned RESET_ADDR = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_req,
  input logic               di,
  input logic               ack,
  input logic               irq,
  input logic [VEC_W-1:0]   vec_addr,
  input logic               irq_pending,
  input logic               gie_q
);
  p_req_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_req) |=> irq_pending);

  p_irq_needs_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_pending && gie_q));

  p_vec_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (vec_addr == VEC_W'(RESET_ADDR)));

  p_vec_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vec_addr != VEC_W'(RESET_ADDR)));

  p_ack_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (!irq && !gie_q));

  p_di_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    di |=> !gie_q);
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W),
                                     .RESET_ADDR(RESET_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .di(di), .ack(ack),
  .irq(irq), .vec_addr(vec_addr), .irq_pending(irq_pending), .gie_q(gie_q)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  localparam int N = 11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] src_req;
  logic        reg_wr;
  logic [0:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        ei, di, reti, ack, irq, irq_pending;
  logic [15:0] vec_addr;

  int checks = 0, errors = 0;
  logic [N-1:0] m_pend, m_en;
  bit m_gie;

  always #10 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ei(ei), .di(di), .reti(reti), .ack(ack), .irq(irq),
    .vec_addr(vec_addr), .irq_pending(irq_pending)
  );

  function automatic int winner(logic [N-1:0] p, logic [N-1:0] e);
    for (int i = 0; i < N; i++) if (p[i] && e[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] exp_rd(logic [0:0] a, logic [N-1:0] e);
    return a ? {5'b0, e[10:8]} : e[7:0];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int w;
    bit ei_exp;
    w = winner(m_pend, m_en);
    ei_exp = m_gie && (w >= 0);
    chk(tag, "R4 irq", irq, ei_exp);
    chk(tag, "R5/R6 vec", vec_addr, ei_exp ? 32'(2 * (w + 1)) : 0);
    chk(tag, "R2 irq_pending", irq_pending, |m_pend);
    chk(tag, "R3 rdata", reg_rdata, exp_rd(reg_addr, m_en));
  endtask

  task automatic cycle(string tag, logic [N-1:0] rq, bit wr, logic [0:0] a,
                       logic [7:0] wd, bit e, bit d, bit r, bit k);
    int w;
    logic [N-1:0] np;
    @(negedge clk);
    src_req = rq; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    ei = e; di = d; reti = r; ack = k;
    #2;
    compare(tag);
    w = winner(m_pend, m_en);
    np = m_pend;
    if (k && m_gie && w >= 0) begin
      np[w] = 1'b0;
      m_gie = 0;
    end else if (d) m_gie = 0;
    else if (e || r) m_gie = 1;
    m_pend = np | rq;
    if (wr) begin
      if (a == 0) m_en[7:0] = wd;
      else m_en[10:8] = wd[2:0];
    end
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1EC7));
    rst_n = 0; src_req = '0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    ei = 0; di = 0; reti = 0; ack = 0;
    m_pend = '0; m_en = '0; m_gie = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); #2;
    compare("R1 in reset");
    reg_addr = 1; #1;
    compare("R1 in reset hi byte");
    rst_n = 1;
    cycle("R1 after release", '0, 0, 0, 8'h00, 0, 0, 0, 0);
    // R3: unused high bits read zero, byte lanes independent
    cycle("R3 wr hi", '0, 1, 1, 8'hFF, 0, 0, 0, 0);
    cycle("R3 rd hi", '0, 0, 1, 8'h00, 0, 0, 0, 0);
    cycle("R3 wr lo", '0, 1, 0, 8'hA5, 0, 0, 0, 0);
    cycle("R3 rd lo", '0, 0, 0, 8'h00, 0, 0, 0, 0);
    // R4: disabled source (bit 1 of A5 is 0) pends but no irq
    cycle("R4 req dis", 11'h002, 0, 0, 8'h00, 1, 0, 0, 0);
    cycle("R4 dis pend", '0, 0, 0, 8'h00, 0, 0, 0, 0);
    cycle("R4 enable all", '0, 1, 0, 8'hFF, 0, 0, 0, 0);
    // R6: sources 9 and 3 added; 1 still lowest
    cycle("R6 req", 11'h208, 0, 0, 8'h00, 0, 0, 0, 0);
    cycle("R6 prio", '0, 0, 0, 8'h00, 0, 0, 0, 0);
    // R7: accept source 1, then return
    cycle("R7 ack", '0, 0, 0, 8'h00, 0, 0, 0, 1);
    cycle("R7 closed", '0, 0, 0, 8'h00, 0, 0, 0, 0);
    cycle("R7 ack ignored", '0, 0, 0, 8'h00, 0, 0, 0, 1);
    cycle("R7 reti", '0, 0, 0, 8'h00, 0, 0, 1, 0);
    // R9: request on winner (3) during its acceptance keeps it pending
    cycle("R9 ack+req", 11'h008, 0, 0, 8'h00, 0, 0, 0, 1);
    cycle("R9 kept", 11'h008, 0, 0, 8'h00, 0, 0, 1, 0);
    cycle("R9 merged ack", '0, 0, 0, 8'h00, 0, 0, 0, 1);
    cycle("R9 cleared", '0, 0, 0, 8'h00, 1, 0, 0, 0);
    // R8: DI beats EI
    cycle("R8 ei+di", '0, 0, 0, 8'h00, 1, 1, 0, 0);
    cycle("R8 off", '0, 0, 0, 8'h00, 0, 0, 0, 0);
    cycle("R8 reti on", '0, 0, 0, 8'h00, 0, 0, 1, 0);
    cycle("R5 vec", '0, 0, 1, 8'h00, 0, 0, 0, 0);
    for (int n = 0; n < 3000; n++) begin
      logic [N-1:0] rq;
      rq = '0;
      for (int b = 0; b < N; b++) rq[b] = ($urandom % 20) == 0;
      cycle("random", rq, ($urandom % 16) == 0, 1'($urandom),
            8'($urandom), ($urandom % 6) == 0, ($urandom % 10) == 0,
            ($urandom % 8) == 0, ($urandom % 3) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule